// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-on-Less-Than

This block is a purely combinational 32-bit arithmetic logic unit for a simple integer datapath. It is assembled from a row of identical one-bit slices. Each slice holds a full adder, an optional inversion of its second operand, and a small output selector. Carries pass from the least significant slice to the most significant one. A 3-bit operation code picks one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. A Zero flag reports an all-zero result, so a branch can test two registers for equality by subtracting them.

Subtraction uses the two's complement identity a − b = a + ~b + 1. One control bit, the most significant bit of the operation code, inverts every bit of the second operand and also supplies the carry into slice 0. For set-on-less-than the unit computes a − b and takes the sign bit from the top slice. That sign bit is routed back into the "less" input of slice 0, and the less input of every other slice is tied low. The comparison uses the raw sign of the difference and applies no overflow correction.

The block has no clock, no reset and no internal state: its outputs follow its inputs through gates only.

Top module: `slice_alu`

## Requirements
- R1: Operation code 3'b000 gives res = opa AND opb, bit by bit.
- R2: Operation code 3'b001 gives res = opa OR opb, bit by bit.
- R3: Operation code 3'b010 gives res = (opa + opb) mod 2^32. The carry out of the top slice equals bit 32 of the full sum.
- R4: Operation code 3'b110 gives res = (opa − opb) mod 2^32. This is formed by inverting opb and forcing the carry into bit 0 to 1.
- R5: Operation code 3'b111 gives res[0] = bit 31 of (opa − opb) mod 2^32, taken as the raw sign with no overflow correction, and res[31:1] = 0.
- R6: zero is 1 exactly when all 32 bits of res are 0, whatever the operation.
- R7: Operation codes 3'b011, 3'b100 and 3'b101 give res = 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl  | input  | 3  | Operation code: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than |
| opa  | input  | 32 | First operand |
| opb  | input  | 32 | Second operand |
| res  | output | 32 | Result word |
| zero | output | 1  | High when every bit of res is 0 |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs change. They assume the ripple chain has settled before they look, and they assume ctl is never X or Z. The bench therefore drives all three inputs together from one process and samples a fixed time after each change, well before the next change. The set-on-less-than check assumes the raw sign of the difference rather than a true signed comparison. The stimulus includes an overflowing case, 0x80000000 compared with 1, so that this assumption is exercised deliberately and not by accident.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [2:0] {
        CTL_AND  = 3'b000,
        CTL_OR   = 3'b001,
        CTL_ADD  = 3'b010,
        CTL_RSV3 = 3'b011,
        CTL_RSV4 = 3'b100,
        CTL_RSV5 = 3'b101,
        CTL_SUB  = 3'b110,
        CTL_SLT  = 3'b111
    } alu_ctl_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

endpackage

// File: rtl/slice_alu_decode.sv
module slice_alu_decode
    import slice_alu_pkg::*;
(
    input  logic [2:0] ctl,
    output logic       bneg,
    output slice_sel_e sel,
    output logic       en
);

    always_comb begin
        bneg = ctl[2];
        sel  = SEL_AND;
        en   = 1'b1;
        unique case (ctl)
            CTL_AND: sel = SEL_AND;
            CTL_OR:  sel = SEL_OR;
            CTL_ADD: sel = SEL_SUM;
            CTL_SUB: sel = SEL_SUM;
            CTL_SLT: sel = SEL_LESS;
            default: begin
                sel = SEL_AND;
                en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
    import slice_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       less,
    input  logic       binv,
    input  logic       cin,
    input  slice_sel_e sel,
    input  logic       en,
    output logic       result,
    output logic       sum,
    output logic       cout
);

    logic bx;
    logic pick;

    assign bx   = b ^ binv;
    assign sum  = a ^ bx ^ cin;
    assign cout = (a & bx) | (a & cin) | (bx & cin);

    always_comb begin
        unique case (sel)
            SEL_AND:  pick = a & bx;
            SEL_OR:   pick = a | bx;
            SEL_SUM:  pick = sum;
            SEL_LESS: pick = less;
            default:  pick = 1'b0;
        endcase
    end

    assign result = en & pick;

endmodule

// File: rtl/slice_alu_zero.sv
module slice_alu_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    output logic         all_clear
);

    assign all_clear = ~(|word);

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   ctl,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res,
    output logic         zero
);

    localparam int MSB = W - 1;

    logic       bneg;
    slice_sel_e sel;
    logic       en;
    logic [W-1:0] sum_tap;
    logic       sign_fb;
    logic       carry_out;

    slice_alu_decode u_dec (
        .ctl  (ctl),
        .bneg (bneg),
        .sel  (sel),
        .en   (en)
    );

    for (genvar i = 0; i < W; i++) begin : stage
        logic cin_w;
        logic less_w;
        logic cout_w;
        if (i == 0) begin : g_first
            assign cin_w  = bneg;
            assign less_w = sign_fb;
        end else begin : g_rest
            assign cin_w  = stage[i-1].cout_w;
            assign less_w = 1'b0;
        end
        slice_alu_bit u_bit (
            .a      (opa[i]),
            .b      (opb[i]),
            .less   (less_w),
            .binv   (bneg),
            .cin    (cin_w),
            .sel    (sel),
            .en     (en),
            .result (res[i]),
            .sum    (sum_tap[i]),
            .cout   (cout_w)
        );
    end

    assign sign_fb   = sum_tap[MSB];
    assign carry_out = stage[MSB].cout_w;

    slice_alu_zero #(.W(W)) u_zero (
        .word      (res),
        .all_clear (zero)
    );

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int W = 32
) (
    input logic [2:0]   ctl,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] res,
    input logic         zero,
    input logic [W-1:0] sum_tap,
    input logic         carry_out
);

    logic [W:0]   wide_add;
    logic [W-1:0] diff;

    always_comb begin
        wide_add = {1'b0, opa} + {1'b0, opb};
        diff     = opa - opb;
        if (ctl == 3'b000) AST_AND_WORD: assert (res == (opa & opb)); // R1
        if (ctl == 3'b001) AST_OR_WORD: assert (res == (opa | opb)); // R2
        if (ctl == 3'b010) AST_ADD_WIDE: assert ({carry_out, res} == wide_add); // R3
        if (ctl == 3'b010 || ctl == 3'b110) AST_SUM_TAP: assert (res == sum_tap); // R3
        if (ctl == 3'b110) AST_SUB_WORD: assert (res == diff); // R4
        if (ctl == 3'b111) AST_SLT_SIGN: assert (res == {{(W-1){1'b0}}, diff[W-1]}); // R5
        AST_ZERO_FLAG: assert (zero == (res == '0)); // R6
        if (ctl == 3'b011 || ctl == 3'b100 || ctl == 3'b101) AST_RSV_CLEAR: assert (res == '0 && zero); // R7
    end

endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (
    .ctl       (ctl),
    .opa       (opa),
    .opb       (opb),
    .res       (res),
    .zero      (zero),
    .sum_tap   (sum_tap),
    .carry_out (carry_out)
);

// File: tb/slice_alu_test.sv
`timescale 1ns/1ps
module slice_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl = 3'b000;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] res;
    logic        zero;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    slice_alu uut (
        .ctl  (ctl),
        .opa  (opa),
        .opb  (opb),
        .res  (res),
        .zero (zero)
    );

    localparam int NV = 16;
    localparam logic [98:0] VEC [0:NV-1] = '{
        {3'b000, 32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000},
        {3'b000, 32'hAAAAAAAA, 32'h55555555, 32'h00000000},
        {3'b001, 32'h12340000, 32'h00005678, 32'h12345678},
        {3'b001, 32'h00000000, 32'h00000000, 32'h00000000},
        {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
        {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},
        {3'b110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE},
        {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},
        {3'b110, 32'h00001234, 32'h00001234, 32'h00000000},
        {3'b111, 32'h00000003, 32'h00000005, 32'h00000001},
        {3'b111, 32'h00000005, 32'h00000003, 32'h00000000},
        {3'b111, 32'hFFFFFFFF, 32'h00000000, 32'h00000001},
        {3'b111, 32'h80000000, 32'h00000001, 32'h00000000},
        {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
        {3'b100, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
        {3'b101, 32'h7FFFFFFF, 32'h80000000, 32'h00000000}
    };

    function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        d = a - b;
        case (c)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return d;
            3'b111:  return {31'b0, d[31]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_check(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp);
        ctl = c;
        opa = a;
        opb = b;
        #2;
        tests++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s ctl=%b a=%h b=%h res=%h expected=%h", tag(c), c, a, b, res, exp);
        end
        tests++;
        if (zero !== (exp == 32'h0)) begin
            fails++;
            $display("FAIL R6 ctl=%b a=%h b=%h zero=%b expected=%b", c, a, b, zero, exp == 32'h0);
        end
        #3;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] ra;
        logic [31:0] rb;
        seed = 32'h1F2E3D4C;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle inputs: AND of zeros gives zero result, zero flag high (R1, R6)
        tests++;
        if (res !== 32'h0 || zero !== 1'b1) begin
            fails++;
            $display("FAIL R6 idle res=%h zero=%b expected res=00000000 zero=1", res, zero);
        end
        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
        end
        // Corner operands across every code: R1 R2 R3 R4 R5 R7
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 4; x++) begin
                for (int y = 0; y < 4; y++) begin
                    ra = (x == 0) ? 32'h0 : (x == 1) ? 32'hFFFFFFFF : (x == 2) ? 32'h80000000 : 32'h7FFFFFFF;
                    rb = (y == 0) ? 32'h0 : (y == 1) ? 32'hFFFFFFFF : (y == 2) ? 32'h80000000 : 32'h7FFFFFFF;
                    apply_check(3'(c), ra, rb, model(3'(c), ra, rb));
                end
            end
        end
        // Pseudo-random operands for all codes
        for (int n = 0; n < 300; n++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            ra = seed;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            rb = (n % 5 == 0) ? ra : seed;
            apply_check(3'(n % 8), ra, rb, model(3'(n % 8), ra, rb));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule